// File: doc/BRIEF.md
# Register-Configured Serial Transmitter

This block turns bytes written over a small chip-select bus into asynchronous serial frames on a single output line. A host first programs three setup registers: word length, parity enable and stop-bit count. It then writes a data value to the data address. That write starts a frame: a low start bit, 5 to 8 data bits sent least significant first, an optional even parity bit, and one or two high stop bits.

Each bit on the line lasts a fixed number of system clock cycles, set by a parameter. A status output, `tx_rdy`, goes high while the stop bits are on the line. It stays low during the start, data and parity bits and while the line is idle. A host can therefore use its rising edge as a sign that the payload has left the block.

The frame engine takes a copy of the setup registers at the moment a frame starts. Changing the setup during a frame therefore only affects the next frame. A data write that arrives while a frame is still on the line is dropped.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the `tx` line is high, `tx_rdy` is low, and the setup is 8 data bits, no parity and one stop bit.
- R2: A write to address 0 while the line is idle starts a frame whose first bit is a low start bit.
- R3: Address 1 holds the word-length code in bits 1:0; code c selects 5+c data bits. The data bits follow the start bit, least significant bit first.
- R4: Address 2 bit 0 enables parity. When it is enabled, one bit equal to the XOR of the data bits sent (even parity) follows the last data bit.
- R5: A high stop bit ends every frame. When address 3 bit 0 is set, a second high stop bit follows it, and then the line returns to idle high.
- R6: Every bit of a frame lasts exactly BIT_CYCLES clock cycles (default 16). The start bit begins in the cycle after the write edge.
- R7: `tx_rdy` is high exactly while a stop bit is on the line. It is low during the start, data and parity bits and while idle.
- R8: A register is written only on a clock edge where `cs_n` is low and `wr_en` is high. Any other bus activity changes nothing.
- R9: A data write that arrives while a frame is in progress is ignored. It neither alters the current frame nor starts another one.
- R10: A setup write made during a frame does not change that frame. It applies from the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | ADDR_W (2) | Register address |
| wdata | input | DATA_W (8) | Write data |
| tx | output | 1 | Serial output line, idle high |
| tx_rdy | output | 1 | High while stop bits are being sent |

## Verification
The bench builds the block with its defaults: 8-bit data bus, 2-bit address and 16 cycles per bit. With an 8-bit bus, all four word-length codes can be reached, so random frames cover every combination of 5 to 8 data bits, parity on or off, and one or two stop bits. Because the bit period is 16 cycles, the bench can sample each bit at its midpoint and also probe the last cycle of the start bit and the first cycle of the first data bit, which pins the period to the exact cycle. Directed cases add writes with the select held high, writes with the strobe low, and data and setup writes made in the middle of a frame.

// File: rtl/stx_pkg.sv
package stx_pkg;

  // Frame position of the transmit engine
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } frame_state_e;

  // Line setup held by the register block and snapshotted per frame
  typedef struct packed {
    logic [1:0] len_code;   // data bits = MIN_DATA_BITS + len_code
    logic       par_en;     // even parity bit after data
    logic       two_stop;   // second stop bit
  } line_cfg_t;

  localparam int MIN_DATA_BITS = 5;

endpackage

// File: rtl/stx_regs.sv
module stx_regs
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output line_cfg_t         cfg_o,
  output logic              launch_o,
  output logic [DATA_W-1:0] launch_data_o
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PAR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(3);

  line_cfg_t cfg_q, cfg_d;
  logic      wr_hit;

  assign wr_hit = !cs_n && wr_en;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_hit) begin
      unique case (addr)
        A_LEN:   cfg_d.len_code = wdata[1:0];
        A_PAR:   cfg_d.par_en   = wdata[0];
        A_STOP:  cfg_d.two_stop = wdata[0];
        default: cfg_d = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.len_code <= 2'd3;
      cfg_q.par_en   <= 1'b0;
      cfg_q.two_stop <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o         = cfg_q;
  assign launch_o      = wr_hit && (addr == A_DATA);
  assign launch_data_o = wdata;

  // R8: no select or no strobe leaves the setup untouched
  a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !wr_en) |=> $stable(cfg_q));

endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int BIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = run_i;
  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_en || !run_i) cnt_q <= cnt_d;
  end

  // R6: every bit boundary restarts the period count
  a_r6_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R6: idle keeps the divider parked so a frame starts on a full period
  a_r6_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/stx_frame.sv
module stx_frame
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_cfg_t         cfg_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              tx_o,
  output logic              rdy_o,
  output logic              busy_o
);

  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  frame_state_e      state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              par_q, par_d;
  line_cfg_t         cfg_q, cfg_d;
  logic [DATA_W-1:0] keep;
  logic [IDX_W-1:0]  last_idx;

  // Mask of bits that belong to the word length requested at launch
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      keep[i] = (i < (MIN_DATA_BITS + int'(cfg_i.len_code)));
    end
  end

  assign last_idx = IDX_W'(cfg_q.len_code) + IDX_W'(MIN_DATA_BITS - 1);

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (launch_i) begin
          state_d = ST_START;
          shreg_d = data_i & keep;
          par_d   = ^(data_i & keep);
          cfg_d   = cfg_i;
          idx_d   = '0;
        end
      end
      ST_START: begin
        if (tick_i) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (tick_i) begin
          shreg_d = shreg_q >> 1;
          if (idx_q == last_idx) begin
            state_d = cfg_q.par_en ? ST_PARITY : ST_STOP1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_PARITY: begin
        if (tick_i) state_d = ST_STOP1;
      end
      ST_STOP1: begin
        if (tick_i) state_d = cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
      end
      ST_STOP2: begin
        if (tick_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      shreg_q        <= '0;
      idx_q          <= '0;
      par_q          <= 1'b0;
      cfg_q.len_code <= 2'd3;
      cfg_q.par_en   <= 1'b0;
      cfg_q.two_stop <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      par_q   <= par_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = shreg_q[0];
      ST_PARITY: tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end

  assign rdy_o  = (state_q == ST_STOP1) || (state_q == ST_STOP2);
  assign busy_o = (state_q != ST_IDLE);

  // R2: an accepted data write puts a start bit on the line next cycle
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && launch_i) |=> (state_q == ST_START && !tx_o));

  // R6: frame position only moves on a bit boundary
  a_r6_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tick_i) |=> $stable(state_q));

  // R9: a data write mid-frame leaves the shifted payload alone
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && launch_i && !tick_i) |=> $stable(shreg_q));

  // R10: the frame snapshot of the setup is frozen while busy
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(cfg_q));

  // R7: ready is only raised while the line carries a high stop level
  a_r7_rdy_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> tx_o);

  // R5: the frame always leaves through a stop bit
  a_r5_exit_via_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(rdy_o));

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import stx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx,
  output logic              tx_rdy
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  line_cfg_t         cfg;
  logic              launch;
  logic [DATA_W-1:0] launch_data;
  logic              bit_tick;
  logic              busy;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  stx_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .cs_n         (cs_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .cfg_o        (cfg),
    .launch_o     (launch),
    .launch_data_o(launch_data)
  );

  stx_baud #(
    .BIT_CYCLES(BIT_CYCLES)
  ) u_baud (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run_i (busy),
    .tick_o(bit_tick)
  );

  stx_frame #(
    .DATA_W(DATA_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cfg_i   (cfg),
    .launch_i(launch),
    .data_i  (launch_data),
    .tick_i  (bit_tick),
    .tx_o    (tx),
    .rdy_o   (tx_rdy),
    .busy_o  (busy)
  );

  // R1: line is idle high with ready low whenever no frame runs
  a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> (tx && !tx_rdy));

endmodule

// File: tb/serial_tx_core_test.sv
`timescale 1ns/1ps
module serial_tx_core_test;

  localparam int BC = 16;

  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic       tx;
  logic       tx_rdy;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  serial_tx_core #(.DATA_W(8), .ADDR_W(2), .BIT_CYCLES(BC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .tx(tx), .tx_rdy(tx_rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic setup(input int len, input bit par, input bit two);
    bus_write(2'd1, 8'(len - 5));
    bus_write(2'd2, {7'd0, par});
    bus_write(2'd3, {7'd0, two});
  endtask

  // Expected line level of bit k of a frame
  function automatic bit exp_tx(input logic [7:0] d, input int len, input bit par, input int k);
    bit p;
    p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    if (k == 0) return 1'b0;
    if (k <= len) return d[k-1];
    if (par && k == len + 1) return p;
    return 1'b1;
  endfunction

  function automatic bit exp_rdy(input int len, input bit par, input int k);
    return (k > len + (par ? 1 : 0));
  endfunction

  function automatic string bit_tag(input int len, input bit par, input int k);
    if (k == 0) return "R2 start";
    if (k <= len) return "R3 data";
    if (par && k == len + 1) return "R4 parity";
    return "R5 stop";
  endfunction

  // poke: 0 none, 1 mid-frame data write (R9), 2 mid-frame setup change (R10)
  task automatic send_check(input logic [7:0] d, input int len, input bit par,
                            input bit two, input int poke);
    int nbits;
    nbits = 2 + len + (par ? 1 : 0) + (two ? 1 : 0);
    bus_write(2'd0, d);
    repeat (BC/2 - 1) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      chk(tx == exp_tx(d, len, par, k), bit_tag(len, par, k), tx, exp_tx(d, len, par, k));
      chk(tx_rdy == exp_rdy(len, par, k), "R7 ready", tx_rdy, exp_rdy(len, par, k));
      if (k == 2 && poke == 1) begin
        bus_write(2'd0, ~d);
        repeat (BC - 2) @(negedge clk);
      end else if (k == 2 && poke == 2) begin
        bus_write(2'd2, {7'd0, ~par});
        repeat (BC - 2) @(negedge clk);
      end else begin
        repeat (BC) @(negedge clk);
      end
    end
    chk(tx == 1'b1, "R5 idle after frame", tx, 1);
    chk(tx_rdy == 1'b0, "R7 ready low after frame", tx_rdy, 0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R1 reset tx", tx, 1);
    chk(tx_rdy == 1'b0, "R1 reset rdy", tx_rdy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx == 1'b1, "R1 idle tx", tx, 1);

    // R1: default setup is 8 bits, no parity, one stop
    send_check(8'hA6, 8, 1'b0, 1'b0, 0);

    // R6: exact bit boundaries
    bus_write(2'd0, 8'h01);
    repeat (BC - 1) @(negedge clk);
    chk(tx == 1'b0, "R6 last start cycle", tx, 0);
    @(negedge clk);
    chk(tx == 1'b1, "R6 first data cycle", tx, 1);
    repeat (BC * 10) @(negedge clk);
    chk(tx == 1'b1, "R6 idle", tx, 1);

    // R8: select high, then strobe low: nothing starts, nothing changes
    @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (BC * 2) @(negedge clk);
    chk(tx == 1'b1, "R8 no select", tx, 1);
    @(negedge clk);
    cs_n = 1'b0; wr_en = 1'b0; addr = 2'd1; wdata = 8'h00;
    @(negedge clk);
    addr = 2'd0;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (BC * 2) @(negedge clk);
    chk(tx == 1'b1, "R8 no strobe", tx, 1);
    // length must still be 8 bits
    send_check(8'hE5, 8, 1'b0, 1'b0, 0);

    // Directed corners
    setup(5, 1'b1, 1'b0);
    send_check(8'h05, 5, 1'b1, 1'b0, 0);
    setup(8, 1'b1, 1'b1);
    send_check(8'hFF, 8, 1'b1, 1'b1, 0);

    // R9: data write during a frame is dropped
    setup(6, 1'b0, 1'b1);
    send_check(8'h2D, 6, 1'b0, 1'b1, 1);
    repeat (BC * 3) @(negedge clk);
    chk(tx == 1'b1, "R9 no second frame", tx, 1);

    // R10: setup change during a frame applies to the next one
    setup(7, 1'b0, 1'b0);
    send_check(8'h53, 7, 1'b0, 1'b0, 2);
    send_check(8'h53, 7, 1'b1, 1'b0, 0);

    // Random frames
    void'($urandom(32'd4242));
    for (int n = 0; n < 24; n++) begin
      int len; bit par; bit two; logic [7:0] d;
      len = int'($urandom_range(8, 5));
      par = 1'($urandom_range(1, 0));
      two = 1'($urandom_range(1, 0));
      d   = 8'($urandom());
      setup(len, par, two);
      send_check(d, len, par, two, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule